// File: doc/BRIEF.md
# Running-Histogram Column Median Filter

This block computes the median of a square, odd-sized window of pixels as that window slides down one image column, one row at a time. It keeps one bin per intensity level, holding how many window pixels have that value. It also keeps the current median and a count of window pixels whose value is strictly less than that median. No window is ever sorted.

A new column starts with a start pulse. The block clears every bin and accepts all window pixels on the entering-row stream. It then walks the median up from zero to the correct level and emits the result. For each later row position, the caller sends the window's oldest row on the leaving-row stream and the new row on the entering-row stream. Each of those pixels updates one bin and, if it lies below the current median, the below-median count. The median is then moved up or down one level per cycle until it settles, and one result is emitted. The caller supplies the actual pixels. Image storage and edge handling stay outside the block.

Top module: `colmed_filter`

## Requirements
- R1: After reset, `medValid`, `addReady` and `dropReady` are all low until a column is started.
- R2: A `newCol` pulse clears the histogram. The block then raises `addReady` only, accepts exactly WIN×WIN entering pixels, and emits one result equal to the median of those pixels.
- R3: For each later window position, the block accepts exactly WIN leaving pixels and then exactly WIN entering pixels. It then emits one result equal to the median of the updated window.
- R4: Within a step, leaving pixels come first: `dropReady` is high and `addReady` is low at the start of a step, and the two readies are never high together.
- R5: While the median is being adjusted, and in the cycle a result is presented, both readies are low. `medValid` is a one-cycle pulse.
- R6: `newCol` is honoured after reset and between windows (before the first leaving pixel of a step). It discards the previous window entirely.
- R7: The median is the smallest level m for which the number of window pixels at or below m exceeds (WIN×WIN−1)/2. This holds with repeated values and at the extreme levels 0 and LEVELS−1.
- R8: `medOut` holds its value between result pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| newCol | input | 1 | Start a new column (clear and full fill) |
| addValid | input | 1 | Entering-row pixel valid |
| addPix | input | $clog2(LEVELS) | Entering-row pixel value |
| addReady | output | 1 | Entering-row pixel accepted when high with `addValid` |
| dropValid | input | 1 | Leaving-row pixel valid |
| dropPix | input | $clog2(LEVELS) | Leaving-row pixel value |
| dropReady | output | 1 | Leaving-row pixel accepted when high with `dropValid` |
| medValid | output | 1 | One-cycle pulse: `medOut` holds a new result |
| medOut | output | $clog2(LEVELS) | Median of the current window |

## Verification
Full fills with pseudo-random pixels check that the median walk starting from level zero lands correctly. Long runs of random rows then check the incremental path, where the below-median count has to follow bins on both sides of the median. A column of all zeros that fills with rows of 255 forces the median to jump across the whole level range and exercises both extremes. Windows full of repeated values, such as a few levels packed into the window, separate a correct at-or-below rule from an off-by-one in the settle test. A restart between windows shows that nothing from the previous column survives.

// File: rtl/colmed_pkg.sv
package colmed_pkg;
  // Per-cycle commands from the sequencer to the histogram datapath
  typedef struct packed {
    logic clr;   // clear all bins, median and below count
    logic inc;   // add one pixel to the window
    logic dec;   // remove one pixel from the window
    logic adj;   // move the median one level
    logic cap;   // latch the settled median onto the output
  } mfStrobe_t;
endpackage

// File: rtl/colmed_ctrl.sv
module colmed_ctrl
  import colmed_pkg::*;
#(
  parameter int WIN = 3
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      newCol,
  input  logic      addValid,
  input  logic      dropValid,
  input  logic      adjDone,
  output logic      addReady,
  output logic      dropReady,
  output logic      medValid,
  output mfStrobe_t stb
);
  localparam int AREA  = WIN * WIN;
  localparam int CNT_W = $clog2(AREA + 1);

  typedef enum logic [2:0] {S_IDLE, S_FILL, S_DROP, S_ADD, S_ADJ, S_EMIT} state_t;

  state_t           state;
  logic [CNT_W-1:0] cnt;
  logic             colTake, addFire, dropFire;

  always_comb begin
    colTake   = newCol && (state == S_IDLE || (state == S_DROP && cnt == '0));
    dropReady = (state == S_DROP) && !colTake;
    addReady  = (state == S_FILL) || (state == S_ADD);
    addFire   = addReady && addValid;
    dropFire  = dropReady && dropValid;
    medValid  = (state == S_EMIT);
    stb.clr   = colTake;
    stb.inc   = addFire;
    stb.dec   = dropFire;
    stb.adj   = (state == S_ADJ) && !adjDone;
    stb.cap   = (state == S_ADJ) && adjDone;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else if (colTake) begin
      state <= S_FILL;
      cnt   <= '0;
    end else begin
      case (state)
        S_FILL: if (addFire) begin
          if (cnt == CNT_W'(AREA - 1)) begin
            state <= S_ADJ;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        S_DROP: if (dropFire) begin
          if (cnt == CNT_W'(WIN - 1)) begin
            state <= S_ADD;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        S_ADD: if (addFire) begin
          if (cnt == CNT_W'(WIN - 1)) begin
            state <= S_ADJ;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        S_ADJ:   if (adjDone) state <= S_EMIT;
        S_EMIT:  state <= S_DROP;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/colmed_dpath.sv
module colmed_dpath
  import colmed_pkg::*;
#(
  parameter int WIN    = 3,
  parameter int LEVELS = 256
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  mfStrobe_t                 stb,
  input  logic [$clog2(LEVELS)-1:0] pix,
  output logic                      adjDone,
  output logic [$clog2(LEVELS)-1:0] medOut
);
  localparam int PIX_W = $clog2(LEVELS);
  localparam int AREA  = WIN * WIN;
  localparam int CNT_W = $clog2(AREA + 1);
  localparam int HALF  = (AREA - 1) / 2;

  logic [CNT_W-1:0] hist [LEVELS];
  logic [PIX_W-1:0] med;
  logic [CNT_W-1:0] below;
  logic [CNT_W-1:0] curBin, prevBin;
  logic [CNT_W:0]   upSum;
  logic             needUp, needDown, pixBelow;

  // One counter per intensity level
  for (genvar i = 0; i < LEVELS; i++) begin : g_bin
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                hist[i] <= '0;
      else if (stb.clr)                          hist[i] <= '0;
      else if (stb.inc && pix == PIX_W'(i))      hist[i] <= hist[i] + 1'b1;
      else if (stb.dec && pix == PIX_W'(i))      hist[i] <= hist[i] - 1'b1;
    end
  end

  always_comb begin
    curBin   = hist[med];
    prevBin  = hist[PIX_W'(med - 1'b1)];
    upSum    = {1'b0, below} + {1'b0, curBin};
    needDown = below > CNT_W'(HALF);
    needUp   = upSum <= (CNT_W + 1)'(HALF);
    adjDone  = !needDown && !needUp;
    pixBelow = pix < med;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      med   <= '0;
      below <= '0;
    end else if (stb.clr) begin
      med   <= '0;
      below <= '0;
    end else if (stb.inc) begin
      if (pixBelow) below <= below + 1'b1;
    end else if (stb.dec) begin
      if (pixBelow) below <= below - 1'b1;
    end else if (stb.adj) begin
      if (needDown) begin
        med   <= med - 1'b1;
        below <= below - prevBin;
      end else begin
        med   <= med + 1'b1;
        below <= below + curBin;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       medOut <= '0;
    else if (stb.cap) medOut <= med;
  end
endmodule

// File: rtl/colmed_filter.sv
module colmed_filter
  import colmed_pkg::*;
#(
  parameter int WIN    = 3,
  parameter int LEVELS = 256
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      newCol,
  input  logic                      addValid,
  input  logic [$clog2(LEVELS)-1:0] addPix,
  output logic                      addReady,
  input  logic                      dropValid,
  input  logic [$clog2(LEVELS)-1:0] dropPix,
  output logic                      dropReady,
  output logic                      medValid,
  output logic [$clog2(LEVELS)-1:0] medOut
);
  localparam int PIX_W = $clog2(LEVELS);

  mfStrobe_t        stb;
  logic             adjDone;
  logic [PIX_W-1:0] pix;

  assign pix = stb.dec ? dropPix : addPix;

  colmed_ctrl #(.WIN(WIN)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .newCol(newCol), .addValid(addValid),
    .dropValid(dropValid), .adjDone(adjDone), .addReady(addReady),
    .dropReady(dropReady), .medValid(medValid), .stb(stb)
  );

  colmed_dpath #(.WIN(WIN), .LEVELS(LEVELS)) u_dpath (
    .clk(clk), .rst_n(rst_n), .stb(stb), .pix(pix),
    .adjDone(adjDone), .medOut(medOut)
  );
endmodule

// File: rtl/colmed_filter_chk.sv
module colmed_filter_chk #(
  parameter int PIX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             addReady,
  input logic             dropReady,
  input logic             medValid,
  input logic [PIX_W-1:0] medOut
);
  // R4
  readies_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(addReady && dropReady));

  // R5
  emit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    medValid |-> (!addReady && !dropReady));

  // R5
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    medValid |=> !medValid);

  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !medValid |=> (medValid || $stable(medOut)));
endmodule

bind colmed_filter colmed_filter_chk #(.PIX_W($clog2(LEVELS))) u_chk (
  .clk(clk), .rst_n(rst_n), .addReady(addReady), .dropReady(dropReady),
  .medValid(medValid), .medOut(medOut)
);

// File: tb/colmed_filter_tb.sv
module colmed_filter_tb;
  localparam int WIN    = 3;
  localparam int LEVELS = 256;
  localparam int PIX_W  = 8;
  localparam int HALF   = (WIN * WIN - 1) / 2;

  logic             clk = 0;
  logic             rst_n = 0;
  logic             newCol = 0;
  logic             addValid = 0;
  logic [PIX_W-1:0] addPix = '0;
  logic             dropValid = 0;
  logic [PIX_W-1:0] dropPix = '0;
  logic             addReady, dropReady, medValid;
  logic [PIX_W-1:0] medOut;

  int tests = 0;
  int fails = 0;
  int expQ[$];
  string tagQ[$];
  int win[$];
  int unsigned seed = 32'h1234_5678;
  int lastMed = 0;
  bit seenPulse = 0;
  bit holdBad = 0;

  always #5 clk = ~clk;

  colmed_filter #(.WIN(WIN), .LEVELS(LEVELS)) u_dut (
    .clk(clk), .rst_n(rst_n), .newCol(newCol), .addValid(addValid),
    .addPix(addPix), .addReady(addReady), .dropValid(dropValid),
    .dropPix(dropPix), .dropReady(dropReady), .medValid(medValid),
    .medOut(medOut)
  );

  function automatic int rnd(input int span, input int base);
    seed = seed * 32'd1103515245 + 32'd12345;
    return base + int'((seed >> 16) % span);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Monitor: compare each result against the scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (seenPulse && !medValid && int'(medOut) != lastMed) holdBad = 1;
      if (medValid) begin
        check(!addReady && !dropReady, "R5 readies during result", int'(addReady | dropReady), 0);
        if (seenPulse) begin
          check(!holdBad, "R8 output held between results", int'(holdBad), 0);
        end
        holdBad = 0;
        if (expQ.size() == 0) begin
          check(0, "R3 unexpected result", int'(medOut), -1);
        end else begin
          int e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          check(int'(medOut) == e, t, int'(medOut), e);
        end
        lastMed = int'(medOut);
        seenPulse = 1;
      end
    end
  end

  task automatic sendAdd(input int p);
    addPix = PIX_W'(p);
    addValid = 1;
    while (!addReady) @(negedge clk);
    @(negedge clk);
    addValid = 0;
    win.push_back(p);
  endtask

  task automatic sendDrop(input int p);
    dropPix = PIX_W'(p);
    dropValid = 1;
    while (!dropReady) @(negedge clk);
    @(negedge clk);
    dropValid = 0;
  endtask

  task automatic expectMed(input string tag);
    int s[$];
    s = win;
    s.sort();
    expQ.push_back(s[HALF]);
    tagQ.push_back(tag);
  endtask

  task automatic waitIdle();
    while (expQ.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic startCol(input string tag);
    newCol = 1;
    @(negedge clk);
    newCol = 0;
    win.delete();
    check(addReady && !dropReady, tag, int'({addReady, dropReady}), 2);
  endtask

  task automatic stepRow(input int row[WIN], input string tag);
    // R4: leaving pixels are requested first
    check(dropReady && !addReady, "R4 step opens on leaving stream",
          int'({dropReady, addReady}), 2);
    for (int j = 0; j < WIN; j++) begin
      sendDrop(win[0]);
      void'(win.pop_front());
    end
    for (int j = 0; j < WIN; j++) sendAdd(row[j]);
    expectMed(tag);
    waitIdle();
  endtask

  initial begin
    int row[WIN];
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    check(!medValid && !addReady && !dropReady, "R1 idle after reset",
          int'({medValid, addReady, dropReady}), 0);

    // R2: random full fill
    startCol("R2 fill opens entering stream");
    for (int k = 0; k < WIN * WIN; k++) sendAdd(rnd(256, 0));
    expectMed("R2 fill median");
    waitIdle();

    // R3: random rows down the column
    for (int s = 0; s < 10; s++) begin
      for (int j = 0; j < WIN; j++) row[j] = rnd(256, 0);
      stepRow(row, "R3 step median");
    end

    // R6 and R7: restart with all zeros, then jump to the top level
    startCol("R6 restart opens entering stream");
    for (int k = 0; k < WIN * WIN; k++) sendAdd(0);
    expectMed("R7 all-zero median");
    waitIdle();
    for (int s = 0; s < 4; s++) begin
      for (int j = 0; j < WIN; j++) row[j] = LEVELS - 1;
      stepRow(row, "R7 extreme level median");
    end

    // R6: restart with repeated values, old window must be gone
    startCol("R6 second restart");
    for (int k = 0; k < WIN * WIN; k++) sendAdd(2 + 3 * (k % 3));
    expectMed("R6 fresh window median");
    waitIdle();

    // R7: ties, narrow value range
    for (int s = 0; s < 20; s++) begin
      for (int j = 0; j < WIN; j++) row[j] = rnd(4, 100);
      stepRow(row, "R7 tie median");
    end

    // R3: mixed wide and narrow rows
    for (int s = 0; s < 10; s++) begin
      for (int j = 0; j < WIN; j++) row[j] = (s % 2) ? rnd(256, 0) : rnd(3, 0);
      stepRow(row, "R3 mixed step median");
    end

    repeat (5) @(negedge clk);
    check(expQ.size() == 0, "R3 all results produced", expQ.size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL R3 watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule